// File: doc/BRIEF.md
# Fourth-Order Sinc Decimator with Conversion-Mode Control

This block turns the one-bit output of a delta-sigma modulator into signed multi-bit samples. Each incoming bit is first mapped to +1 or -1. It then passes through four cascaded accumulators, which run once per accepted bit. Four cascaded differencing stages follow, and they run once per decimation period of `DECIM` accepted bits. The combined response is a sinc filter raised to the fourth power. The full-precision sum is rescaled to an 18-bit two's-complement code. In that code, -1 full scale is 0x20000 and +1 full scale clips to 0x1FFFF.

A start pulse clears every filter register and begins a conversion. The mode is sampled on that start pulse and chooses between two behaviours:

- **Single-shot conversion:** the filter waits four full decimation periods so that its window holds only fresh input. It then delivers one result and wipes its history again. After that it ignores the bit stream until the next start.
- **Continuous conversion:** the history is never cleared. The first three decimated values are withheld while the window fills, and every later decimated value is delivered.

Top module: `sinc4_decim`

## Requirements
- R1: After reset, `result_o` is 0 and `result_vld_o` is 0, and no result is produced until a start pulse.
- R2: `bit_i`=1 enters the filter as +1 and `bit_i`=0 as -1. The DC gain is `DECIM`^4, and the output code is the full sum times 2^(17-4·log2(DECIM)). With `DECIM`=16, a settled all-zero stream gives 0x20000, and a stream repeating 1,1,1,0 gives 0x10000.
- R3: A settled all-one stream yields the largest positive code 0x1FFFF and not a wrapped negative value.
- R4: With `mode_i`=0 at start, `result_vld_o` pulses exactly once. The pulse comes in the cycle after the 4·`DECIM`-th accepted bit. After it, no further pulse occurs until the next start, however many bits arrive.
- R5: With `mode_i`=1 at start, the first three decimation boundaries produce no pulse. The pulse comes on the fourth boundary and on every boundary after it, with each pulse lasting one cycle.
- R6: In continuous mode the filter keeps its history across outputs. After 4·`DECIM` ones followed by zeros, the first boundary in the zeros gives 2·(`DECIM`^4 − 2·C(`DECIM`,4)), which is 0x1E390 for `DECIM`=16. The fourth boundary gives 0x20000.
- R7: The mode is captured only on a start pulse. A change of `mode_i` during a conversion has no effect on it.
- R8: A start pulse during a conversion discards all state and restarts the boundary count. No result pulse occurs in the cycle after a start.
- R9: Only bits presented with `bit_vld_i`=1 are counted. Idle cycles between strobes do not alter the result: alternating bits with irregular gaps give 0.
- R10: `result_o` changes only together with a `result_vld_o` pulse and otherwise holds the last result.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | One-cycle pulse that clears the filter and begins a conversion |
| mode_i | input | 1 | Conversion mode sampled at start: 0 single-shot, 1 continuous |
| bit_i | input | 1 | Modulator output bit |
| bit_vld_i | input | 1 | Qualifies `bit_i` for this cycle |
| result_o | output | 18 | Signed filtered result |
| result_vld_o | output | 1 | One-cycle strobe marking a new `result_o` |

## Verification
The hardest case to reach from the ports is proving that continuous mode really carries history across an output boundary. A constant stream gives the same settled value whether or not the state was cleared. The stimulus therefore drives a full window of ones and then switches to zeros. The value on the first boundary inside the zeros depends on both the old and the new data, and that value has a closed form the bench checks exactly. The same step continues for four boundaries, with `mode_i` flipped mid-run, to show that the latched mode keeps the stream going.

// File: rtl/sinc4_pkg.sv
package sinc4_pkg;

    typedef enum logic {
        MODE_SINGLE = 1'b0,
        MODE_CONT   = 1'b1
    } conv_mode_e;

    localparam int unsigned STAGES = 4;

endpackage

// File: rtl/sinc4_ctrl.sv
module sinc4_ctrl
    import sinc4_pkg::*;
#(
    parameter int unsigned DECIM = 16
) (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic start_i,
    input  logic mode_i,
    input  logic bit_vld_i,
    output logic clr_o,
    output logic en_o,
    output logic tick_o,
    output logic emit_o
);

    localparam int unsigned LOG2R = $clog2(DECIM);
    localparam int unsigned CNT_W = (LOG2R < 1) ? 1 : LOG2R;
    localparam logic [CNT_W-1:0] LAST_SMP = CNT_W'(DECIM - 1);
    localparam logic [1:0] SETTLE_LAST = 2'(STAGES - 1);

    typedef struct packed {
        logic             run;
        conv_mode_e       mode;
        logic [CNT_W-1:0] smp;
        logic [1:0]       dec;
    } ctrl_t;

    ctrl_t ctrl_d, ctrl_q;
    logic  en, tick, emit;

    always_comb begin
        ctrl_d = ctrl_q;
        en     = ctrl_q.run & bit_vld_i & ~start_i;
        tick   = en & (ctrl_q.smp == LAST_SMP);
        emit   = tick & (ctrl_q.dec == SETTLE_LAST);

        if (start_i) begin
            ctrl_d.run  = 1'b1;
            ctrl_d.mode = conv_mode_e'(mode_i);
            ctrl_d.smp  = '0;
            ctrl_d.dec  = '0;
        end else if (en) begin
            ctrl_d.smp = tick ? '0 : ctrl_q.smp + 1'b1;
            if (tick && ctrl_q.dec != SETTLE_LAST) begin
                ctrl_d.dec = ctrl_q.dec + 1'b1;
            end
            if (emit && ctrl_q.mode == MODE_SINGLE) begin
                ctrl_d.run = 1'b0;
            end
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            ctrl_q <= '{run: 1'b0, mode: MODE_SINGLE, smp: '0, dec: '0};
        end else begin
            ctrl_q <= ctrl_d;
        end
    end

    assign en_o   = en;
    assign tick_o = tick;
    assign emit_o = emit;
    assign clr_o  = start_i | (emit & (ctrl_q.mode == MODE_SINGLE));

endmodule

// File: rtl/sinc4_integ.sv
module sinc4_integ
    import sinc4_pkg::*;
#(
    parameter int unsigned ACC_W = 18
) (
    input  logic                    clk_i,
    input  logic                    rst_ni,
    input  logic                    clr_i,
    input  logic                    en_i,
    input  logic                    bit_i,
    output logic signed [ACC_W-1:0] sum_o
);

    typedef struct packed {
        logic [STAGES-1:0][ACC_W-1:0] acc;
    } integ_t;

    integ_t integ_d, integ_q;
    logic [ACC_W-1:0] step;

    always_comb begin
        step    = bit_i ? ACC_W'(1) : {ACC_W{1'b1}};
        integ_d = integ_q;
        if (clr_i) begin
            integ_d.acc = '0;
        end else if (en_i) begin
            integ_d.acc[0] = integ_q.acc[0] + step;
            for (int k = 1; k < STAGES; k++) begin
                integ_d.acc[k] = integ_q.acc[k] + integ_q.acc[k-1];
            end
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            integ_q <= '0;
        end else begin
            integ_q <= integ_d;
        end
    end

    // value the last accumulator takes on this accepted bit
    assign sum_o = $signed(integ_q.acc[STAGES-1] + integ_q.acc[STAGES-2]);

endmodule

// File: rtl/sinc4_comb.sv
module sinc4_comb
    import sinc4_pkg::*;
#(
    parameter int unsigned ACC_W = 18
) (
    input  logic                    clk_i,
    input  logic                    rst_ni,
    input  logic                    clr_i,
    input  logic                    tick_i,
    input  logic signed [ACC_W-1:0] din_i,
    output logic signed [ACC_W-1:0] dout_o
);

    typedef struct packed {
        logic [STAGES-1:0][ACC_W-1:0] dly;
    } comb_t;

    comb_t comb_d, comb_q;
    logic [STAGES-1:0][ACC_W-1:0] diff;

    always_comb begin
        diff[0] = din_i - comb_q.dly[0];
        for (int k = 1; k < STAGES; k++) begin
            diff[k] = diff[k-1] - comb_q.dly[k];
        end

        comb_d = comb_q;
        if (clr_i) begin
            comb_d.dly = '0;
        end else if (tick_i) begin
            comb_d.dly[0] = din_i;
            for (int k = 1; k < STAGES; k++) begin
                comb_d.dly[k] = diff[k-1];
            end
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            comb_q <= '0;
        end else begin
            comb_q <= comb_d;
        end
    end

    assign dout_o = $signed(diff[STAGES-1]);

endmodule

// File: rtl/sinc4_scale.sv
module sinc4_scale #(
    parameter int unsigned ACC_W = 18,
    parameter int unsigned FRAC  = 16,
    parameter int unsigned OUT_W = 18
) (
    input  logic signed [ACC_W-1:0] din_i,
    output logic        [OUT_W-1:0] dout_o
);

    localparam logic signed [OUT_W:0] MAX_POS = {2'b00, {(OUT_W-1){1'b1}}};

    logic signed [OUT_W:0] ext;

    generate
        if (FRAC <= OUT_W - 1) begin : g_up
            localparam int unsigned SH = OUT_W - 1 - FRAC;
            logic signed [OUT_W:0] wide;
            assign wide = (OUT_W+1)'(din_i);
            assign ext  = wide <<< SH;
        end else begin : g_dn
            localparam int unsigned SH = FRAC - OUT_W + 1;
            logic signed [ACC_W-1:0] shr;
            assign shr = din_i >>> SH;
            assign ext = shr[OUT_W:0];
        end
    endgenerate

    always_comb begin
        if (ext > MAX_POS) begin
            dout_o = MAX_POS[OUT_W-1:0];
        end else begin
            dout_o = ext[OUT_W-1:0];
        end
    end

endmodule

// File: rtl/sinc4_decim.sv
module sinc4_decim #(
    parameter int unsigned DECIM = 16,
    parameter int unsigned OUT_W = 18
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             start_i,
    input  logic             mode_i,
    input  logic             bit_i,
    input  logic             bit_vld_i,
    output logic [OUT_W-1:0] result_o,
    output logic             result_vld_o
);

    localparam int unsigned LOG2R = $clog2(DECIM);
    localparam int unsigned FRAC  = 4 * LOG2R;
    localparam int unsigned ACC_W = FRAC + 2;

    logic clr, en, tick, emit;
    logic signed [ACC_W-1:0] integ_sum, comb_out;
    logic [OUT_W-1:0] scaled;

    sinc4_ctrl #(.DECIM(DECIM)) u_ctrl (
        .clk_i     (clk_i),
        .rst_ni    (rst_ni),
        .start_i   (start_i),
        .mode_i    (mode_i),
        .bit_vld_i (bit_vld_i),
        .clr_o     (clr),
        .en_o      (en),
        .tick_o    (tick),
        .emit_o    (emit)
    );

    sinc4_integ #(.ACC_W(ACC_W)) u_integ (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .clr_i  (clr),
        .en_i   (en),
        .bit_i  (bit_i),
        .sum_o  (integ_sum)
    );

    sinc4_comb #(.ACC_W(ACC_W)) u_comb (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .clr_i  (clr),
        .tick_i (tick),
        .din_i  (integ_sum),
        .dout_o (comb_out)
    );

    sinc4_scale #(.ACC_W(ACC_W), .FRAC(FRAC), .OUT_W(OUT_W)) u_scale (
        .din_i  (comb_out),
        .dout_o (scaled)
    );

    typedef struct packed {
        logic [OUT_W-1:0] res;
        logic             vld;
    } out_t;

    out_t out_d, out_q;

    always_comb begin
        out_d     = out_q;
        out_d.vld = emit;
        if (emit) begin
            out_d.res = scaled;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            out_q <= '0;
        end else begin
            out_q <= out_d;
        end
    end

    assign result_o     = out_q.res;
    assign result_vld_o = out_q.vld;

endmodule

// File: rtl/sinc4_decim_chk.sv
module sinc4_decim_chk #(
    parameter int unsigned OUT_W = 18
) (
    input logic             clk_i,
    input logic             rst_ni,
    input logic             start_i,
    input logic             bit_vld_i,
    input logic [OUT_W-1:0] result_o,
    input logic             result_vld_o
);

    AST_VLD_ONE_CYCLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
        result_vld_o |=> !result_vld_o); // R5

    AST_RESULT_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !result_vld_o |-> $stable(result_o)); // R10

    AST_VLD_NEEDS_BIT: assert property (@(posedge clk_i) disable iff (!rst_ni)
        result_vld_o |-> $past(bit_vld_i)); // R9

    AST_START_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
        start_i |=> !result_vld_o); // R8

endmodule

bind sinc4_decim sinc4_decim_chk #(.OUT_W(OUT_W)) u_chk (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .start_i      (start_i),
    .bit_vld_i    (bit_vld_i),
    .result_o     (result_o),
    .result_vld_o (result_vld_o)
);

// File: tb/sinc4_decim_test.sv
module sinc4_decim_test;

    localparam int R = 16;

    logic        clk_i = 1'b0;
    logic        rst_ni = 1'b0;
    logic        start_i = 1'b0;
    logic        mode_i = 1'b0;
    logic        bit_i = 1'b0;
    logic        bit_vld_i = 1'b0;
    logic [17:0] result_o;
    logic        result_vld_o;

    int n_run = 0;
    int n_fail = 0;
    logic        got_vld;
    logic [17:0] got_res;

    always #4 clk_i = ~clk_i;

    sinc4_decim #(.DECIM(R), .OUT_W(18)) uut (
        .clk_i        (clk_i),
        .rst_ni       (rst_ni),
        .start_i      (start_i),
        .mode_i       (mode_i),
        .bit_i        (bit_i),
        .bit_vld_i    (bit_vld_i),
        .result_o     (result_o),
        .result_vld_o (result_vld_o)
    );

    task automatic chk(input string req, input int act, input int exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    task automatic pulse_start(input logic m);
        @(negedge clk_i);
        start_i = 1'b1;
        mode_i  = m;
        @(negedge clk_i);
        start_i = 1'b0;
    endtask

    task automatic send_bit(input logic b, input int gap);
        repeat (gap) @(negedge clk_i);
        @(negedge clk_i);
        bit_i     = b;
        bit_vld_i = 1'b1;
        @(negedge clk_i);
        bit_vld_i = 1'b0;
        got_vld   = result_vld_o;
        got_res   = result_o;
    endtask

    task automatic t_reset();
        chk("R1 result after reset", int'(result_o), 0);
        chk("R1 valid after reset", int'(result_vld_o), 0);
        for (int i = 0; i < 2 * R; i++) send_bit(1'b1, 0);
        chk("R1 no result without start", int'(result_vld_o), 0);
    endtask

    task automatic t_single_ones();
        int nv = 0; int idx = -1; logic [17:0] v = '0;
        pulse_start(1'b0);
        for (int i = 0; i < 4 * R; i++) begin
            send_bit(1'b1, 0);
            if (got_vld) begin nv++; idx = i; v = got_res; end
        end
        chk("R4 single pulse count", nv, 1);
        chk("R4 single pulse position", idx, 4 * R - 1);
        chk("R3 saturated max code", int'(v), 'h1FFFF);
        nv = 0;
        for (int i = 0; i < 2 * R; i++) begin
            send_bit(1'b0, 0);
            if (got_vld) nv++;
        end
        chk("R4 idle after single result", nv, 0);
        chk("R10 result held", int'(result_o), 'h1FFFF);
    endtask

    task automatic t_single_values();
        pulse_start(1'b0);
        for (int i = 0; i < 4 * R; i++) send_bit(1'b0, 0);
        chk("R2 all zeros valid", int'(got_vld), 1);
        chk("R2 all zeros code", int'(got_res), 'h20000);
        pulse_start(1'b0);
        for (int i = 0; i < 4 * R; i++) send_bit((i % 4) != 3, 0);
        chk("R2 pattern 1110 valid", int'(got_vld), 1);
        chk("R2 pattern 1110 code", int'(got_res), 'h10000);
    endtask

    task automatic t_continuous();
        int nv = 0; int bad = 0;
        logic [17:0] first_v = '0;
        pulse_start(1'b1);
        for (int i = 0; i < 4 * R; i++) begin
            send_bit(1'b1, 0);
            if (got_vld) begin
                nv++;
                if (i != 4 * R - 1) bad++;
            end
        end
        chk("R5 first three suppressed, fourth shown", nv, 1);
        chk("R5 no early pulse", bad, 0);
        chk("R3 continuous max code", int'(got_res), 'h1FFFF);
        mode_i = 1'b0; // R7: must not affect running conversion
        nv = 0; bad = 0;
        for (int i = 0; i < 4 * R; i++) begin
            send_bit(1'b0, 0);
            if (got_vld) begin
                if (nv == 0) first_v = got_res;
                nv++;
                if ((i % R) != R - 1) bad++;
            end
        end
        chk("R7 mode change ignored, pulses continue", nv, 4);
        chk("R5 pulse each period", bad, 0);
        chk("R6 history kept across output", int'(first_v), 2 * (65536 - 2 * 1820));
        chk("R6 settled zeros", int'(got_res), 'h20000);
    endtask

    task automatic t_restart();
        int nv = 0;
        pulse_start(1'b1);
        for (int i = 0; i < R / 2; i++) send_bit(1'b0, 0);
        pulse_start(1'b1);
        for (int i = 0; i < 3 * R; i++) begin
            send_bit(1'b1, 0);
            if (got_vld) nv++;
        end
        chk("R8 restart suppresses pulses", nv, 0);
        for (int i = 0; i < R; i++) send_bit(1'b1, 0);
        chk("R8 first pulse after restart", int'(got_vld), 1);
        chk("R8 restart value", int'(got_res), 'h1FFFF);
        pulse_start(1'b0);
        for (int i = 0; i < 2 * R; i++) send_bit(1'b0, 0);
        pulse_start(1'b0);
        nv = 0;
        for (int i = 0; i < 4 * R - 1; i++) begin
            send_bit(1'b1, 0);
            if (got_vld) nv++;
        end
        chk("R8 single restart no early pulse", nv, 0);
        send_bit(1'b1, 0);
        chk("R8 single restart pulse", int'(got_vld), 1);
        chk("R8 single restart value", int'(got_res), 'h1FFFF);
    endtask

    task automatic t_gaps();
        int nv = 0;
        pulse_start(1'b0);
        for (int i = 0; i < 4 * R; i++) begin
            send_bit(i[0], i % 3);
            if (got_vld) nv++;
        end
        chk("R9 gapped stream one pulse", nv, 1);
        chk("R9 alternating gives zero", int'(got_res), 0);
    endtask

    task automatic report();
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    endtask

    initial begin
        repeat (3) @(negedge clk_i);
        rst_ni = 1'b1;
        @(negedge clk_i);
        t_reset();
        t_single_ones();
        t_single_values();
        t_continuous();
        t_restart();
        t_gaps();
        report();
    end

    initial begin
        #(8 * 150000);
        n_run++;
        n_fail++;
        $display("FAIL watchdog expired");
        report();
    end

endmodule